// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Status Flags

This block is the receive side of an I2C target for a microcontroller peripheral. It oversamples SCL and SDA on the system clock, finds START and STOP conditions, and compares each address frame against a programmable 7-bit own address and against the all-zero general call address. After a match it shifts in data bytes, acknowledges each one on the ninth clock, and hands every completed frame to software through a one-byte holding register.

Reception is continuous: SCL is never held low. The next byte shifts in while software is still draining the previous one, and a newer byte replaces an unread one. Software controls the acknowledge level with a control bit. To refuse the last byte of a transfer, software sets that bit once the byte before it has finished. The bit is taken when the eighth bit of a byte has been clocked in, so it takes effect one byte later. Software reads a status register for an interrupt request, data-available, address-match, general-call, direction, and normal or premature stop.

The register bus has four byte registers. Index 0 is control, with bit 0 = NACK select. Index 1 is the own address in bits 6:0. Index 2 is status. Index 3 is received data. Writes take effect on the clock edge. Read data is combinational from `reg_addr`, and the read side effect happens on the edge where `reg_rd` is high.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, `sda_oe` is 0, status reads 0x00, control reads 0x00 and the own-address register reads the reset parameter value.
- R2: A START is SDA falling while SCL is high. The first frame after it is an address whose upper 7 bits match the own-address register, with bit 0 as R/W. A matching address is acknowledged by asserting `sda_oe` for the whole ninth SCL high phase. The own-address register is writable and reads back.
- R3: Address byte 0x00 is acknowledged and sets both status bit 3 (general call) and status bit 2 (address match).
- R4: Status bit 0 (interrupt request) is set on the ninth SCL rising edge of every accepted address or data frame. Writing 1 to status bit 0 clears it, and it sets again on the next accepted frame.
- R5: An accepted address frame loads the address byte into the data register and sets status bit 1 (data available). Reading it is the dummy read. Any read of index 3 clears bit 1.
- R6: Bytes keep being received and acknowledged while bit 1 is still set. An unread byte is replaced, so the data register holds the most recent byte.
- R7: In a write transfer, a data byte is acknowledged when control bit 0 is 0 and released (NACK) when it is 1. The bit is sampled on the SCL falling edge after the eighth data bit, so setting it after a byte completes affects only the next byte.
- R8: A matching address with R/W = 1 is acknowledged and sets status bit 4 (direction). The slave then drives nothing, and later frames produce no interrupt.
- R9: A STOP (SDA rising while SCL is high) in a selected transfer sets status bit 5 at a frame boundary. It sets bit 6 instead if at least two bits of a new frame had been clocked. The last byte stays readable with bit 1 still set. A new START clears bits 2, 3, 4, 5 and 6.
- R10: A non-matching address is not acknowledged. That frame, the bytes after it and the STOP leave status at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_addr | input | 2 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect on data register) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |

## Verification
The bench arms NACK right after the second-to-last byte. A design that samples the control bit too early or too late would refuse the wrong byte or acknowledge the last one. It sends two bytes without reading, so a design that stalls or keeps the oldest byte returns the wrong value. It stops the bus three bits into a frame. A design that counts bits wrongly would report a normal stop or none at all. It also checks that a general call sets both address flags and that a read request silences the slave. It checks that traffic for another address leaves every flag clear.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADR_W   = 7;
    localparam int CNT_W   = 4;
    localparam int REG_AW  = 2;

    localparam logic [REG_AW-1:0] RA_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] RA_OWN  = 2'd1;
    localparam logic [REG_AW-1:0] RA_STAT = 2'd2;
    localparam logic [REG_AW-1:0] RA_DATA = 2'd3;

    localparam logic [CNT_W-1:0] BIT_LAST = 4'd8;
    localparam logic [CNT_W-1:0] BIT_ACK  = 4'd9;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic              addr_hit;
        logic              data_hit;
        logic              gcall;
        logic              rw;
        logic [BYTE_W-1:0] value;
    } frm_evt_t;

    function automatic logic is_gcall(input logic [BYTE_W-1:0] b);
        return b == '0;
    endfunction

    function automatic logic addr_ok(input logic [BYTE_W-1:0] b,
                                     input logic [ADR_W-1:0]  own);
        return (b[BYTE_W-1:1] == own) || is_gcall(b);
    endfunction
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [STAGES-1:0] scl_ch;
    logic [STAGES-1:0] sda_ch;
    logic              scl_d, sda_d, scl_s;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ch[g] <= 1'b1;
                    sda_ch[g] <= 1'b1;
                end else begin
                    scl_ch[g] <= scl_i;
                    sda_ch[g] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ch[g] <= 1'b1;
                    sda_ch[g] <= 1'b1;
                end else begin
                    scl_ch[g] <= scl_ch[g-1];
                    sda_ch[g] <= sda_ch[g-1];
                end
            end
        end
    end

    assign scl_s = scl_ch[STAGES-1];
    assign sda_s = sda_ch[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_c  = scl_s & scl_d & ~sda_s & sda_d;
    assign stop_c   = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/i2c_srx_frame.sv
module i2c_srx_frame
    import i2c_srx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_c,
    input  logic             stop_c,
    input  logic [ADR_W-1:0] own_addr,
    input  logic             nack_ctl,
    output logic             sda_oe,
    output frm_evt_t         evt,
    output logic             stop_evt,
    output logic             err_evt
);
    phase_t            ph_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shf_q;
    logic              hit_q, gc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            cnt_q    <= '0;
            shf_q    <= '0;
            hit_q    <= 1'b0;
            gc_q     <= 1'b0;
            sda_oe   <= 1'b0;
            evt      <= '0;
            stop_evt <= 1'b0;
            err_evt  <= 1'b0;
        end else begin
            evt      <= '0;
            stop_evt <= 1'b0;
            err_evt  <= 1'b0;
            if (start_c) begin
                ph_q   <= PH_ADDR;
                cnt_q  <= '0;
                hit_q  <= 1'b0;
                gc_q   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                if (ph_q == PH_DATA || ph_q == PH_SKIP) begin
                    if (cnt_q >= 4'd2 && cnt_q <= BIT_LAST) err_evt  <= 1'b1;
                    else                                    stop_evt <= 1'b1;
                end
                ph_q   <= PH_IDLE;
                cnt_q  <= '0;
                sda_oe <= 1'b0;
            end else if (ph_q != PH_IDLE) begin
                if (scl_rise) begin
                    if (cnt_q < BIT_LAST) begin
                        shf_q <= {shf_q[BYTE_W-2:0], sda_s};
                        cnt_q <= cnt_q + 4'd1;
                    end else if (cnt_q == BIT_LAST) begin
                        cnt_q <= BIT_ACK;
                        if (ph_q == PH_ADDR && hit_q) begin
                            evt.addr_hit <= 1'b1;
                            evt.gcall    <= gc_q;
                            evt.rw       <= shf_q[0];
                            evt.value    <= shf_q;
                        end else if (ph_q == PH_DATA) begin
                            evt.data_hit <= 1'b1;
                            evt.value    <= shf_q;
                        end
                    end
                end else if (scl_fall) begin
                    if (cnt_q == BIT_LAST) begin
                        if (ph_q == PH_ADDR) begin
                            hit_q  <= addr_ok(shf_q, own_addr);
                            gc_q   <= is_gcall(shf_q);
                            sda_oe <= addr_ok(shf_q, own_addr);
                        end else if (ph_q == PH_DATA) begin
                            sda_oe <= ~nack_ctl;
                        end
                    end else if (cnt_q == BIT_ACK) begin
                        cnt_q  <= '0;
                        sda_oe <= 1'b0;
                        if (ph_q == PH_ADDR) begin
                            if (!hit_q)        ph_q <= PH_IDLE;
                            else if (shf_q[0]) ph_q <= PH_SKIP;
                            else               ph_q <= PH_DATA;
                        end
                    end
                end
            end
        end
    end

    // R7: the acknowledge drive only starts right after the eighth bit
    assert_ack_after_eighth_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> ($past(cnt_q) == BIT_LAST));

    // R10: nothing is driven while the slave is not part of a transfer
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE) |-> !sda_oe);

    // R8: a read request never yields a data frame event
    assert_skip_no_data_R8: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_SKIP) |=> !evt.data_hit);
endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
    import i2c_srx_pkg::*;
#(
    parameter logic [ADR_W-1:0] RST_OWN = 7'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  frm_evt_t          evt,
    input  logic              start_c,
    input  logic              stop_evt,
    input  logic              err_evt,
    output logic [ADR_W-1:0]  own_addr,
    output logic              nack_ctl
);
    logic [BYTE_W-1:0] ctrl_q, buf_q;
    logic [ADR_W-1:0]  own_q;
    logic irq_q, full_q, am_q, gc_q, dir_q, stp_q, est_q;
    logic frame_in, wr_stat, rd_data;

    assign frame_in = evt.addr_hit | evt.data_hit;
    assign wr_stat  = reg_wr && reg_addr == RA_STAT;
    assign rd_data  = reg_rd && reg_addr == RA_DATA;
    assign own_addr = own_q;
    assign nack_ctl = ctrl_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            own_q  <= RST_OWN;
            buf_q  <= '0;
            {irq_q, full_q, am_q, gc_q, dir_q, stp_q, est_q} <= '0;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) ctrl_q <= reg_wdata;
            if (reg_wr && reg_addr == RA_OWN)  own_q  <= reg_wdata[ADR_W-1:0];

            if (frame_in)                     irq_q <= 1'b1;
            else if (wr_stat && reg_wdata[0]) irq_q <= 1'b0;

            if (frame_in) begin
                full_q <= 1'b1;
                buf_q  <= evt.value;
            end else if (rd_data) begin
                full_q <= 1'b0;
            end

            if (start_c) begin
                {am_q, gc_q, dir_q, stp_q, est_q} <= '0;
            end else begin
                if (evt.addr_hit) begin
                    am_q  <= 1'b1;
                    gc_q  <= evt.gcall;
                    dir_q <= evt.rw;
                end
                if (stop_evt)                     stp_q <= 1'b1;
                else if (wr_stat && reg_wdata[5]) stp_q <= 1'b0;
                if (err_evt)                      est_q <= 1'b1;
                else if (wr_stat && reg_wdata[6]) est_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = ctrl_q;
            RA_OWN:  reg_rdata = {1'b0, own_q};
            RA_STAT: reg_rdata = {1'b0, est_q, stp_q, dir_q, gc_q, am_q, full_q, irq_q};
            default: reg_rdata = buf_q;
        endcase
    end

    assert_irq_on_frame_R4: assert property (@(posedge clk) disable iff (rst)
        frame_in |=> irq_q);

    assert_full_on_frame_R5: assert property (@(posedge clk) disable iff (rst)
        frame_in |=> full_q);

    assert_read_drains_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !frame_in) |=> !full_q);

    assert_gcall_has_match_R3: assert property (@(posedge clk) disable iff (rst)
        gc_q |-> am_q);
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
    import i2c_srx_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADR_W-1:0]  RST_OWN     = 7'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata
);
    logic             sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic             stop_evt, err_evt, nack_ctl;
    logic [ADR_W-1:0] own_addr;
    frm_evt_t         evt;

    i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    i2c_srx_frame u_frame (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
        .own_addr(own_addr), .nack_ctl(nack_ctl), .sda_oe(sda_oe),
        .evt(evt), .stop_evt(stop_evt), .err_evt(err_evt)
    );

    i2c_srx_regs #(.RST_OWN(RST_OWN)) u_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt(evt), .start_c(start_c), .stop_evt(stop_evt),
        .err_evt(err_evt), .own_addr(own_addr), .nack_ctl(nack_ctl)
    );
endmodule

// File: tb/i2c_slave_rx_tb.sv
module i2c_slave_rx_tb;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe, sda_line;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_slave_rx u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rread(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H/2); scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H/2); scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wt(H/2); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(H/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wt(H/2); scl_m = 1'b1; wt(H/2);
        acked = ~sda_line;
        wt(H/2); scl_m = 1'b0; wt(H/2);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
        rread(2'd2, v); check("R1 status", v, 8'h00);
        rread(2'd0, v); check("R1 ctrl", v, 8'h00);
        rread(2'd1, v); check("R1 own addr", v, 8'h50);
    endtask

    task automatic t_write_xfer();
        logic [7:0] v; logic a;
        rwrite(2'd1, 8'h3A);
        rread(2'd1, v); check("R2 own addr readback", v, 8'h3A);
        bus_start();
        send_byte(8'h74, a); check("R2 address ack", {7'd0, a}, 8'h01);
        rread(2'd2, v); check("R4 R5 status after address", v, 8'h07);
        rwrite(2'd2, 8'h01);
        rread(2'd2, v); check("R4 irq cleared", v, 8'h06);
        rread(2'd3, v); check("R5 dummy read value", v, 8'h74);
        rread(2'd2, v); check("R5 data flag drained", v, 8'h04);
        send_byte(8'hA5, a); check("R7 data ack", {7'd0, a}, 8'h01);
        rread(2'd2, v); check("R4 irq re-set", v, 8'h07);
        rread(2'd3, v); check("R5 data byte", v, 8'hA5);
        rwrite(2'd2, 8'h01);
        bus_stop();
        rread(2'd2, v); check("R9 normal stop", v, 8'h24);
    endtask

    task automatic t_other_addr();
        logic [7:0] v; logic a;
        bus_start();
        send_byte(8'h22, a); check("R10 no address ack", {7'd0, a}, 8'h00);
        send_byte(8'h5C, a); check("R10 no data ack", {7'd0, a}, 8'h00);
        rread(2'd2, v); check("R10 status quiet", v, 8'h00);
        bus_stop();
        rread(2'd2, v); check("R10 status after stop", v, 8'h00);
    endtask

    task automatic t_gcall_overwrite();
        logic [7:0] v; logic a;
        bus_start();
        send_byte(8'h00, a); check("R3 general call ack", {7'd0, a}, 8'h01);
        rread(2'd2, v); check("R3 match and gc flags", v, 8'h0F);
        send_byte(8'h11, a); check("R6 first unread byte ack", {7'd0, a}, 8'h01);
        send_byte(8'h22, a); check("R6 second byte ack", {7'd0, a}, 8'h01);
        rread(2'd3, v); check("R6 newest byte kept", v, 8'h22);
        rread(2'd2, v); check("R6 status after drain", v, 8'h0D);
        rwrite(2'd2, 8'h01);
        bus_stop();
        rread(2'd2, v); check("R9 stop after gc", v, 8'h2C);
    endtask

    task automatic t_nack_last();
        logic [7:0] v; logic a;
        rwrite(2'd0, 8'h00);
        bus_start();
        send_byte(8'h74, a);
        rread(2'd3, v);
        send_byte(8'h31, a); check("R7 byte n-2 ack", {7'd0, a}, 8'h01);
        send_byte(8'h32, a); check("R7 byte n-1 ack", {7'd0, a}, 8'h01);
        rwrite(2'd0, 8'h01);
        send_byte(8'h33, a); check("R7 final byte nack", {7'd0, a}, 8'h00);
        bus_stop();
        rread(2'd2, v); check("R9 last byte still flagged", v, 8'h27);
        rread(2'd3, v); check("R9 last byte readable", v, 8'h33);
        rwrite(2'd0, 8'h00);
        rwrite(2'd2, 8'h01);
    endtask

    task automatic t_read_req();
        logic [7:0] v; logic a;
        bus_start();
        send_byte(8'h75, a); check("R8 read address ack", {7'd0, a}, 8'h01);
        rread(2'd2, v); check("R8 direction flag", v, 8'h17);
        rwrite(2'd2, 8'h01);
        rread(2'd3, v);
        send_byte(8'hFF, a); check("R8 slave silent", {7'd0, a}, 8'h00);
        rread(2'd2, v); check("R8 no further irq", v, 8'h14);
        bus_stop();
        rread(2'd2, v); check("R9 stop in read", v, 8'h34);
    endtask

    task automatic t_early_stop();
        logic [7:0] v; logic a;
        bus_start();
        rread(2'd2, v); check("R9 start clears flags", v, 8'h00);
        send_byte(8'h74, a);
        rwrite(2'd2, 8'h01);
        rread(2'd3, v);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        rread(2'd2, v); check("R9 premature stop", v, 8'h44);
        bus_start();
        rread(2'd2, v); check("R9 restart clears stop flags", v, 8'h00);
        bus_stop();
        rread(2'd2, v); check("R10 unselected stop", v, 8'h00);
    endtask

    initial begin
        wt(4);
        rst = 1'b0;
        wt(2);
        t_reset();
        t_write_xfer();
        t_other_addr();
        t_gcall_overwrite();
        t_nack_last();
        t_read_req();
        t_early_stop();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule